// File: doc/BRIEF.md
# Variable-Frequency PWM Timer with Shadowed Compares

This block is one channel of an up-counting timer that drives a single PWM output. The low time and the high time of the output come from two separate compare thresholds. The length of each phase is set on its own, so the period changes whenever either threshold changes. When the counter meets the threshold of the current phase, three things happen at once: the output toggles, the counter restarts from a programmable reload value, and the threshold that just matched is refreshed from a shadow (preload) register.

Software keeps the next low-time and high-time values in the two shadow registers. Hardware moves them into the active thresholds at exactly the cycle of the match. This means a late software write can never make the counter miss its compare and run on to rollover. Counting advances only on clocks where the count-enable tick input is high. Each match raises a one-clock event pulse, and a select bit says which threshold fired.

Top module: `vfpwm_timer`

## Requirements
- R1: After reset the output is low, no event pulse is raised, every register holds zero and counting is off, so the output stays low while the enable bit is clear.
- R2: While enabled, the counter rises by one on each clock with `tick` high and wraps modulo 2^CNT_W. With `tick` high on every clock, the low phase lasts ((T_lo − RELOAD) mod 2^CNT_W) + 1 clocks. If `tick` alternates high and low, every phase lasts twice as many clocks.
- R3: A match against the low-time threshold (address 2) while the output is low drives the output high on the next clock and reloads the counter from RELOAD (address 1). The high phase then lasts ((T_hi − RELOAD) mod 2^CNT_W) + 1 ticks.
- R4: A match against the high-time threshold (address 3) while the output is high drives the output low on the next clock and reloads the counter from RELOAD.
- R5: On each match, the active threshold that matched is loaded from its shadow register (address 4 for low time, address 5 for high time). The new value therefore sets the next phase of that kind without any further write. If a software write to an active threshold lands on the clock of its own match, the hardware load takes priority.
- R6: A shadow write that lands on the same clock as the match of its threshold is not used at that match. It takes effect one match later.
- R7: Each match gives a one-clock `evt_pulse` in the same cycle that the output changes. `evt_sel` is 0 for a low-time match (rising output) and 1 for a high-time match (falling output).
- R8: Bit 0 at address 0 enables counting. While it is clear, the counter, the output and the thresholds hold their values and no event is raised. On the clock after the bit is set, the counter loads RELOAD instead of counting, so the first phase lasts one clock longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 reload, 2/3 active low/high threshold, 4/5 low/high shadow) |
| wr_data | input | CNT_W | Write data |
| tick | input | 1 | Count enable for this clock |
| pwm_out | output | 1 | PWM waveform |
| evt_pulse | output | 1 | One-clock match event |
| evt_sel | output | 1 | Which threshold matched: 0 low-time, 1 high-time |

## Verification
The bench builds the timer with a 4-bit counter. This makes every pair of low-time and high-time thresholds reachable: all 256 pairs are swept with a zero reload value, and every reload value is swept against fixed thresholds so that the phase must wrap through rollover. At this width each phase is at most 16 ticks long, so the shadow handover, the write that coincides with a match, the half-rate tick and the enable freeze all run in a few dozen clocks each. Phase lengths are counted at the output and compared with the modular formulas in the requirements.

// File: rtl/vfpwm_pkg.sv
// Package: shared constants and register addresses for the variable-frequency
// PWM timer. Assumes a 3-bit register address space.
package vfpwm_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NUM_CMP = 2;     // low-time threshold, high-time threshold
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_RELOAD = 3'd1,
        RA_THR_LO = 3'd2,
        RA_THR_HI = 3'd3,
        RA_SHD_LO = 3'd4,
        RA_SHD_HI = 3'd5
    } reg_addr_e;

    // Index of each threshold; also the value reported on evt_sel.
    localparam int IDX_LO = 0;
    localparam int IDX_HI = 1;
endpackage

// File: rtl/vfpwm_regs.sv
// Register bank: control enable, reload value, and for each threshold an
// active register plus a shadow register. A hardware load request copies the
// shadow into the active register and beats a software write in the same
// clock. Assumes writes are single-cycle strobes.
module vfpwm_regs
    import vfpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic [NUM_CMP-1:0]              hw_load,
    output logic                            en,
    output logic [CNT_W-1:0]                reload_val,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   thr_act,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   thr_shd
);
    timeunit 1ns;
    timeprecision 100ps;

    // Control and reload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            reload_val <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_CTRL)   en         <= wr_data[0];
            if (wr_addr == RA_RELOAD) reload_val <= wr_data;
        end
    end

    // One active/shadow pair per threshold.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_thr
        localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(int'(RA_THR_LO) + g);
        localparam logic [ADDR_W-1:0] A_SHD = ADDR_W'(int'(RA_SHD_LO) + g);

        // Active threshold: hardware handover first, then software write.
        always_ff @(posedge clk) begin
            if (!rst_n)                            thr_act[g] <= '0;
            else if (hw_load[g])                   thr_act[g] <= thr_shd[g];
            else if (wr_en && wr_addr == A_ACT)    thr_act[g] <= wr_data;
        end

        // Shadow threshold: written only by software.
        always_ff @(posedge clk) begin
            if (!rst_n)                            thr_shd[g] <= '0;
            else if (wr_en && wr_addr == A_SHD)    thr_shd[g] <= wr_data;
        end
    end
endmodule

// File: rtl/vfpwm_match.sv
// Match detector: chooses the threshold for the current output phase and
// flags a hit on an enabled tick. A hit is suppressed on the clock where the
// enable has just risen, because the counter is reloaded then.
module vfpwm_match
    import vfpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            en,
    input  logic                            en_d,
    input  logic                            tick,
    input  logic                            phase_hi,
    input  logic [CNT_W-1:0]                cnt,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   thr_act,
    output logic [NUM_CMP-1:0]              hit
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [CNT_W-1:0] sel_thr;
    logic             any_hit;

    // Threshold selection and hit decode for the current phase.
    always_comb begin
        sel_thr     = phase_hi ? thr_act[IDX_HI] : thr_act[IDX_LO];
        any_hit     = en && en_d && tick && (cnt == sel_thr);
        hit         = '0;
        hit[IDX_LO] = any_hit && !phase_hi;
        hit[IDX_HI] = any_hit &&  phase_hi;
    end
endmodule

// File: rtl/vfpwm_count.sv
// Counter and output phase: counts enabled ticks, reloads on a hit or on the
// enable's rising edge, toggles the output on a hit and registers a one-clock
// event with its source. Assumes hit is one-hot or zero.
module vfpwm_count
    import vfpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     reload_val,
    input  logic [NUM_CMP-1:0]   hit,
    output logic                 en_d,
    output logic [CNT_W-1:0]     cnt,
    output logic                 phase_hi,
    output logic                 evt_pulse,
    output logic                 evt_sel
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Delayed enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= en;
    end

    // Counter: reload on enable rise or hit, else step on enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (en && !en_d)        cnt <= reload_val;
        else if (|hit)               cnt <= reload_val;
        else if (en && tick)         cnt <= cnt + ONE;
    end

    // Output phase: low-time hit raises it, high-time hit lowers it.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_hi <= 1'b0;
        else if (hit[IDX_LO])    phase_hi <= 1'b1;
        else if (hit[IDX_HI])    phase_hi <= 1'b0;
    end

    // Event pulse and its source, aligned with the output change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
            evt_sel   <= 1'b0;
        end else begin
            evt_pulse <= |hit;
            evt_sel   <= hit[IDX_HI];
        end
    end
endmodule

// File: rtl/vfpwm_timer.sv
// Top: variable-frequency PWM timer channel with shadowed thresholds. Wires
// the register bank, the match detector and the counter/phase logic. Assumes
// a synchronous active-low reset and a single clock domain.
module vfpwm_timer
    import vfpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick,
    output logic              pwm_out,
    output logic              evt_pulse,
    output logic              evt_sel
);
    timeunit 1ns;
    timeprecision 100ps;

    logic                           en;
    logic                           en_d;
    logic [CNT_W-1:0]               reload_val;
    logic [NUM_CMP-1:0][CNT_W-1:0]  thr_act;
    logic [NUM_CMP-1:0][CNT_W-1:0]  thr_shd;
    logic [NUM_CMP-1:0]             hit;
    logic [CNT_W-1:0]               cnt;
    logic                           phase_hi;

    vfpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hw_load    (hit),
        .en         (en),
        .reload_val (reload_val),
        .thr_act    (thr_act),
        .thr_shd    (thr_shd)
    );

    vfpwm_match #(.CNT_W(CNT_W)) u_match (
        .en       (en),
        .en_d     (en_d),
        .tick     (tick),
        .phase_hi (phase_hi),
        .cnt      (cnt),
        .thr_act  (thr_act),
        .hit      (hit)
    );

    vfpwm_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (tick),
        .reload_val (reload_val),
        .hit        (hit),
        .en_d       (en_d),
        .cnt        (cnt),
        .phase_hi   (phase_hi),
        .evt_pulse  (evt_pulse),
        .evt_sel    (evt_sel)
    );

    assign pwm_out = phase_hi;
endmodule

// File: rtl/vfpwm_chk.sv
// Checker for vfpwm_timer, attached by bind. Observes ports and the internal
// enable, counter, thresholds and hit strobes.
module vfpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pwm_out,
    input logic             evt_pulse,
    input logic             evt_sel,
    input logic             en,
    input logic             en_d,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_val,
    input logic             hit_lo,
    input logic             hit_hi,
    input logic [CNT_W-1:0] thr_lo,
    input logic [CNT_W-1:0] thr_hi,
    input logic [CNT_W-1:0] shd_lo,
    input logic [CNT_W-1:0] shd_hi
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_d && tick && !hit_lo && !hit_hi) |=> (cnt == $past(cnt) + ONE));

    a_r3_rise_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (pwm_out && cnt == $past(reload_val)));

    a_r4_fall_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> (!pwm_out && cnt == $past(reload_val)));

    a_r5_lo_handover: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (thr_lo == $past(shd_lo)));

    a_r5_hi_handover: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> (thr_hi == $past(shd_hi)));

    a_r7_evt_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> (pwm_out != $past(pwm_out)));

    a_r7_edge_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out != $past(pwm_out)) |-> evt_pulse);

    a_r7_sel_source: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> (evt_sel == !pwm_out));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pwm_out) && !evt_pulse));
endmodule

bind vfpwm_timer vfpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwm_out    (pwm_out),
    .evt_pulse  (evt_pulse),
    .evt_sel    (evt_sel),
    .en         (en),
    .en_d       (en_d),
    .cnt        (cnt),
    .reload_val (reload_val),
    .hit_lo     (hit[0]),
    .hit_hi     (hit[1]),
    .thr_lo     (thr_act[0]),
    .thr_hi     (thr_act[1]),
    .shd_lo     (thr_shd[0]),
    .shd_hi     (thr_shd[1])
);

// File: tb/sim_vfpwm_timer.sv
module sim_vfpwm_timer;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         tick = 1'b1;
    logic         tick_alt = 1'b0;
    logic         pwm_out, evt_pulse, evt_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Tick driver: every clock, or every other clock when tick_alt is set.
    always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

    vfpwm_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out),
        .evt_pulse(evt_pulse), .evt_sel(evt_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        wr_addr = 3'(a);
        wr_data = W'(d);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int rl, input int t_lo, input int t_hi,
                         input int s_lo, input int s_hi);
        do_reset();
        wr(1, rl); wr(2, t_lo); wr(3, t_hi); wr(4, s_lo); wr(5, s_hi);
        wr(0, 1);
    endtask

    task automatic wait_high();
        while (pwm_out !== 1'b1) @(negedge clk);
    endtask

    // Count samples at the present level until it changes.
    task automatic span(output int n);
        logic lvl;
        lvl = pwm_out;
        n = 0;
        while (pwm_out === lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int plen(input int thr, input int rl);
        return ((thr - rl) & (M - 1)) + 1;
    endfunction

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 190000, 0);
        summary();
    end

    initial begin
        int hi, lo, bad;
        @(negedge clk);

        // R1: reset state and no activity while disabled.
        do_reset();
        check(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
        check(evt_pulse == 1'b0, "R1 evt after reset", int'(evt_pulse), 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_out !== 1'b0 || evt_pulse !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R1 idle while disabled", bad, 0);

        // R2 R3 R4: every threshold pair with zero reload.
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                setup(0, a, b, a, b);
                wait_high();
                span(hi);
                span(lo);
                check(hi == plen(b, 0), "R3 high phase length", hi, plen(b, 0));
                check(lo == plen(a, 0), "R4 low phase length", lo, plen(a, 0));
            end
        end

        // R2: reload sweep with modular wrap.
        for (int rl = 0; rl < M; rl++) begin
            setup(rl, 3, 12, 3, 12);
            wait_high();
            span(hi);
            span(lo);
            check(hi == plen(12, rl), "R2 wrapped high length", hi, plen(12, rl));
            check(lo == plen(3, rl), "R2 wrapped low length", lo, plen(3, rl));
        end

        // R5: shadow values take over after each match.
        setup(0, 3, 3, 7, 9);
        wait_high();
        span(hi);
        check(hi == 4, "R5 high before handover", hi, 4);
        span(lo);
        check(lo == 8, "R5 low from shadow", lo, 8);
        span(hi);
        check(hi == 10, "R5 high from shadow", hi, 10);

        // R6: shadow write on the match clock is deferred by one match.
        setup(0, 2, 4, 2, 4);
        wait_high();
        span(hi);                       // now at first low sample
        @(negedge clk);                 // second low sample
        @(negedge clk);                 // third low sample = match clock
        check(pwm_out == 1'b0, "R6 still low on match clock", int'(pwm_out), 0);
        wr(4, 6);                       // captured at the match edge
        check(pwm_out == 1'b1, "R6 rise after match", int'(pwm_out), 1);
        span(hi);
        span(lo);
        check(lo == 3, "R6 old shadow used first", lo, 3);
        span(hi);
        span(lo);
        check(lo == 7, "R6 new shadow one match later", lo, 7);

        // R7: event pulse and source.
        setup(0, 4, 6, 4, 6);
        wait_high();
        check(evt_pulse == 1'b1 && evt_sel == 1'b0, "R7 event on rise",
              {30'd0, evt_pulse, evt_sel}, 2);
        @(negedge clk);
        check(evt_pulse == 1'b0, "R7 pulse one clock", int'(evt_pulse), 0);
        while (pwm_out === 1'b1) @(negedge clk);
        check(evt_pulse == 1'b1 && evt_sel == 1'b1, "R7 event on fall",
              {30'd0, evt_pulse, evt_sel}, 3);
        @(negedge clk);
        check(evt_pulse == 1'b0, "R7 pulse ends", int'(evt_pulse), 0);

        // R2: half-rate tick doubles both phases.
        tick_alt = 1'b1;
        setup(0, 3, 5, 3, 5);
        wait_high();
        span(hi);
        span(lo);
        check(hi == 12, "R2 half-rate high", hi, 12);
        check(lo == 8, "R2 half-rate low", lo, 8);
        tick_alt = 1'b0;
        @(negedge clk);

        // R8: freeze while disabled, then reload on re-enable.
        setup(0, 5, 5, 5, 5);
        wait_high();
        wr(0, 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_out !== 1'b1 || evt_pulse !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R8 frozen while disabled", bad, 0);
        wr(0, 1);
        span(hi);
        check(hi == 7, "R8 reload on enable", hi, 7);

        summary();
    end
endmodule